// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block receives asynchronous serial characters on a single line. A programmable down-counter produces a sample tick. The line is sampled at sixteen ticks per bit in normal mode or eight ticks per bit in double-speed mode. While the line is idle and high, the receiver waits for a low sample. It then follows the frame by counting ticks and decides each bit by a majority vote of three samples near the bit centre. A frame holds one low start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit.

Each completed character is written into a small receive queue together with its own parity-error flag and framing-error flag. The flags are taken under the parity setting that was latched when the character's start bit was detected. The consumer sees the head character, its flags and a data-available flag, and removes the head with a one-cycle read strobe. Reading until the data-available flag drops empties the queue. Dropping the enable abandons any frame in progress, empties the queue and clears the overrun flag on the next clock.

Top module: `uart_os_rx`

## Requirements
- R1: While enabled, the sample tick fires once every `baud_div`+1 clocks, and its counter restarts from `baud_div` each time the enable is raised.
- R2: With `dbl_speed` = 0 a bit lasts 16 ticks, and with `dbl_speed` = 1 it lasts 8 ticks. The mode is latched when the start bit is detected.
- R3: A low sample on an idle line starts a frame. If the start bit votes high (samples 7, 8, 9 of 16, or samples 4, 5, 6 of 8, counted from 0 at the detecting sample), the pulse is treated as a glitch and no character is produced.
- R4: Each bit is the majority of its three vote samples, so a disturbance that corrupts only one of them does not change the received value.
- R5: Data bits are assembled least significant bit first. `par_mode[1]` = 1 adds a parity bit after the data, and `par_mode[1]` = 0 (codes 2'b00 and 2'b01) means no parity bit.
- R6: With parity on, `par_mode[0]` = 0 selects even parity and 1 selects odd parity. A mismatch sets the character's stored parity error. Without parity the stored flag is 0. A later change of `par_mode` does not alter a stored flag.
- R7: A stop bit that votes low sets the character's stored framing error, and the character is still queued.
- R8: The queue holds 2 characters. `rd_avail` is 1 while it is not empty. `rd_data`, `rd_perr` and `rd_ferr` show the oldest character. A cycle with `rd_stb` = 1 and `rd_avail` = 1 removes it.
- R9: A character that completes while the queue is full is discarded, and `overrun` is set and stays set.
- R10: With `rx_en` = 0, reception stops at once and a partial frame is discarded. One clock later `rd_avail` and `overrun` are 0.
- R11: After reset, `rd_avail` = 0 and `overrun` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; 0 aborts and flushes |
| dbl_speed | input | 1 | 1 = 8 samples per bit, 0 = 16 |
| par_mode | input | 2 | [1] parity on, [0] odd parity |
| baud_div | input | 12 | Tick period minus one, in clocks |
| rx_in | input | 1 | Serial input line (idle high) |
| rd_stb | input | 1 | Read strobe: removes the head character |
| rd_data | output | 8 | Head character data |
| rd_avail | output | 1 | Queue holds unread data |
| rd_perr | output | 1 | Parity error of head character |
| rd_ferr | output | 1 | Framing error of head character |
| overrun | output | 1 | Sticky: a character was dropped |

## Verification
The assertions assume that `baud_div` is not 0 whenever the tick-spacing property is active. They also assume that `rd_stb` is raised only as a single-cycle pulse from a consumer that watches `rd_avail`. The stimulus uses divisors of 3 to 5, so a tick never falls on two adjacent clocks. It changes the divisor, speed and parity settings only while the line is idle. Any disturbance pulse it injects inside a bit is shorter than one tick period, so at most one vote sample can see it.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rx_char_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;
endpackage

// File: rtl/uart_os_rx_tick.sv
module uart_os_rx_tick #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= div;
      tick <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= div;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_os_rx_frame.sv
module uart_os_rx_frame
  import uart_os_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     tick,
  input  logic     dbl_speed,
  input  logic [1:0] par_mode,
  input  logic     rx_in,
  output logic     done,
  output rx_char_t char_out
);
  localparam int CNT_W = 4;
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  rx_state_t              state;
  logic [CNT_W-1:0]       s_cnt;
  logic [BIT_W-1:0]       bit_n;
  logic [1:0]             hist;
  logic [DATA_W-1:0]      shreg;
  logic                   dbl_l, par_on_l, odd_l;
  logic                   vote;
  logic [CNT_W-1:0]       last_idx, vote_idx;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
  end
  assign rx_s = sync_q[SYNC_STAGES-1];

  assign vote     = (hist[1] & hist[0]) | (hist[1] & rx_s) | (hist[0] & rx_s);
  assign last_idx = dbl_l ? 4'd7 : 4'd15;
  assign vote_idx = dbl_l ? 4'd6 : 4'd9;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state    <= ST_IDLE;
      s_cnt    <= '0;
      bit_n    <= '0;
      hist     <= 2'b11;
      shreg    <= '0;
      dbl_l    <= 1'b0;
      par_on_l <= 1'b0;
      odd_l    <= 1'b0;
      done     <= 1'b0;
      char_out <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        hist <= {hist[0], rx_s};
        if (state == ST_IDLE) begin
          if (!rx_s) begin
            state         <= ST_START;
            s_cnt         <= 4'd1;
            bit_n         <= '0;
            dbl_l         <= dbl_speed;
            par_on_l      <= par_mode[1];
            odd_l         <= par_mode[0];
            char_out.perr <= 1'b0;
          end
        end else begin
          s_cnt <= (s_cnt == last_idx) ? '0 : s_cnt + 1'b1;
          if (s_cnt == vote_idx) begin
            case (state)
              ST_START: if (vote) state <= ST_IDLE;
              ST_DATA:  shreg <= {vote, shreg[DATA_W-1:1]};
              ST_PAR:   char_out.perr <= vote ^ (^shreg) ^ odd_l;
              ST_STOP: begin
                char_out.data <= shreg;
                char_out.ferr <= ~vote;
                done          <= 1'b1;
                state         <= ST_IDLE;
              end
              default: state <= ST_IDLE;
            endcase
          end else if (s_cnt == last_idx) begin
            case (state)
              ST_START: state <= ST_DATA;
              ST_DATA: begin
                if (bit_n == LAST_BIT) state <= par_on_l ? ST_PAR : ST_STOP;
                bit_n <= bit_n + 1'b1;
              end
              ST_PAR:  state <= ST_STOP;
              default: state <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_os_rx_fifo.sv
module uart_os_rx_fifo
  import uart_os_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     flush,
  input  logic     wr,
  input  rx_char_t wr_char,
  input  logic     rd,
  output rx_char_t head,
  output logic     not_empty,
  output logic     ovr
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  rx_char_t         mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] cnt;
  logic             do_wr, do_rd, full;

  assign full  = (cnt == FULL_CNT);
  assign do_wr = wr && !full;
  assign do_rd = rd && (cnt != '0);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_char;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      ovr  <= 1'b0;
    end else begin
      if (do_wr) wptr <= (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (wr && full) ovr <= 1'b1;
    end
  end

  assign head      = mem[rptr];
  assign not_empty = (cnt != '0);
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_os_rx_pkg::*;
#(
  parameter int DIV_W      = 12,
  parameter int FIFO_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              dbl_speed,
  input  logic [1:0]        par_mode,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              rx_in,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_avail,
  output logic              rd_perr,
  output logic              rd_ferr,
  output logic              overrun
);
  logic     smp_tick;
  logic     frm_done;
  rx_char_t frm_char;
  rx_char_t head;

  uart_os_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .en   (rx_en),
    .div  (baud_div),
    .tick (smp_tick)
  );

  uart_os_rx_frame #(.SYNC_STAGES(2)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .en        (rx_en),
    .tick      (smp_tick),
    .dbl_speed (dbl_speed),
    .par_mode  (par_mode),
    .rx_in     (rx_in),
    .done      (frm_done),
    .char_out  (frm_char)
  );

  uart_os_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .flush     (!rx_en),
    .wr        (frm_done),
    .wr_char   (frm_char),
    .rd        (rd_stb),
    .head      (head),
    .not_empty (rd_avail),
    .ovr       (overrun)
  );

  assign rd_data = head.data;
  assign rd_perr = head.perr;
  assign rd_ferr = head.ferr;
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
  parameter int DIV_W  = 12,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_en,
  input logic [DIV_W-1:0]  baud_div,
  input logic              rd_stb,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_avail,
  input logic              rd_perr,
  input logic              rd_ferr,
  input logic              overrun,
  input logic              smp_tick,
  input logic              frm_done
);
  assert_reset_empty_R11: assert property (@(posedge clk)
    rst |=> !rd_avail && !overrun);

  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (rst)
    rx_en && smp_tick && (baud_div != '0) |=> !smp_tick);

  assert_flush_on_disable_R10: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !rd_avail && !overrun);

  assert_abort_no_frame_R10: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !frm_done);

  assert_head_stable_R8: assert property (@(posedge clk) disable iff (rst)
    rx_en && rd_avail && !rd_stb |=> $stable(rd_data) && $stable(rd_perr) && $stable(rd_ferr));

  assert_avail_from_frame_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_avail) |-> $past(frm_done));

  assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(frm_done) && $past(rd_avail));
endmodule

bind uart_os_rx uart_os_rx_chk #(.DIV_W(DIV_W), .DATA_W(uart_os_rx_pkg::DATA_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .rx_en    (rx_en),
  .baud_div (baud_div),
  .rd_stb   (rd_stb),
  .rd_data  (rd_data),
  .rd_avail (rd_avail),
  .rd_perr  (rd_perr),
  .rd_ferr  (rd_ferr),
  .overrun  (overrun),
  .smp_tick (smp_tick),
  .frm_done (frm_done)
);

// File: tb/test_uart_os_rx.sv
module test_uart_os_rx;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // fields: div[19:16] dbl[15] pm[14:13] data[12:5] flip[4] stop[3] spike[2] eperr[1] eferr[0]
  localparam logic [19:0] VEC [NVEC] = '{
    {4'd3, 1'b0, 2'b00, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'd3, 1'b0, 2'b10, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'd3, 1'b0, 2'b10, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {4'd3, 1'b0, 2'b11, 8'h81, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'd3, 1'b0, 2'b11, 8'h7E, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {4'd3, 1'b1, 2'b10, 8'hC3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'd5, 1'b0, 2'b00, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {4'd3, 1'b0, 2'b00, 8'h96, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {4'd4, 1'b1, 2'b11, 8'h0F, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {4'd3, 1'b0, 2'b01, 8'hF0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_en = 1'b0;
  logic        dbl_speed = 1'b0;
  logic [1:0]  par_mode = 2'b00;
  logic [11:0] baud_div = 12'd3;
  logic        rx_in = 1'b1;
  logic        rd_stb = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_avail, rd_perr, rd_ferr, overrun;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_os_rx i_uart_os_rx (
    .clk(clk), .rst(rst), .rx_en(rx_en), .dbl_speed(dbl_speed),
    .par_mode(par_mode), .baud_div(baud_div), .rx_in(rx_in), .rd_stb(rd_stb),
    .rd_data(rd_data), .rd_avail(rd_avail), .rd_perr(rd_perr),
    .rd_ferr(rd_ferr), .overrun(overrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    rx_in = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic flip,
                            input logic stopv, input logic spike);
    int bp;
    logic [10:0] bits;
    int nb;
    bp = (dbl_speed ? 8 : 16) * (int'(baud_div) + 1);
    bits = '0;
    bits[0] = 1'b0;
    bits[8:1] = d;
    nb = 9;
    if (par_mode[1]) begin
      bits[9] = (^d) ^ par_mode[0] ^ flip;
      nb = 10;
    end
    bits[nb] = stopv;
    nb = nb + 1;
    for (int i = 0; i < nb; i++) begin
      rx_in = bits[i];
      if (spike && i == 4) begin
        repeat (bp / 2 - 1) @(negedge clk);
        rx_in = ~bits[i];
        repeat (3) @(negedge clk);
        rx_in = bits[i];
        repeat (bp - bp / 2 - 2) @(negedge clk);
      end else begin
        repeat (bp) @(negedge clk);
      end
    end
    rx_in = 1'b1;
  endtask

  task automatic read_one;
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 avail after reset", int'(rd_avail), 0);
    chk("R11 overrun after reset", int'(overrun), 0);
    rst = 1'b0;
    @(negedge clk);
    rx_en = 1'b1;
    idle(100);
    chk("R11 avail idle", int'(rd_avail), 0);

    for (int v = 0; v < NVEC; v++) begin
      baud_div  = 12'(VEC[v][19:16]);
      dbl_speed = VEC[v][15];
      par_mode  = VEC[v][14:13];
      idle(20);
      send_frame(VEC[v][12:5], VEC[v][4], VEC[v][3], VEC[v][2]);
      idle(200);
      chk($sformatf("R8 R1 R2 vec %0d avail", v), int'(rd_avail), 1);
      chk($sformatf("R5 R4 vec %0d data", v), int'(rd_data), int'(VEC[v][12:5]));
      chk($sformatf("R6 vec %0d perr", v), int'(rd_perr), int'(VEC[v][1]));
      chk($sformatf("R7 vec %0d ferr", v), int'(rd_ferr), int'(VEC[v][0]));
      read_one();
      chk($sformatf("R8 vec %0d drained", v), int'(rd_avail), 0);
    end

    // R3: short low glitch produces nothing, then a good frame recovers
    baud_div = 12'd3; dbl_speed = 1'b0; par_mode = 2'b00;
    idle(20);
    rx_in = 1'b0;
    repeat (8) @(negedge clk);
    idle(200);
    chk("R3 glitch ignored", int'(rd_avail), 0);
    send_frame(8'h6B, 1'b0, 1'b1, 1'b0);
    idle(100);
    chk("R3 frame after glitch", int'(rd_data), 'h6B);
    read_one();

    // R6: stored parity flag kept after parity setting changes
    par_mode = 2'b10;
    idle(20);
    send_frame(8'h11, 1'b1, 1'b1, 1'b0);
    idle(100);
    par_mode = 2'b00;
    idle(50);
    chk("R6 perr kept after mode change", int'(rd_perr), 1);
    read_one();

    // R9: third frame dropped while full
    send_frame(8'h21, 1'b0, 1'b1, 1'b0); idle(40);
    send_frame(8'h42, 1'b0, 1'b1, 1'b0); idle(40);
    chk("R9 no overrun at two", int'(overrun), 0);
    send_frame(8'h84, 1'b0, 1'b1, 1'b0); idle(100);
    chk("R9 overrun set", int'(overrun), 1);
    chk("R8 head oldest", int'(rd_data), 'h21);
    read_one();
    chk("R8 second entry", int'(rd_data), 'h42);
    chk("R9 overrun sticky", int'(overrun), 1);
    read_one();
    chk("R9 third dropped", int'(rd_avail), 0);

    // R10: disable mid-frame flushes queue and aborts frame
    send_frame(8'h55, 1'b0, 1'b1, 1'b0); idle(40);
    chk("R10 precondition avail", int'(rd_avail), 1);
    rx_in = 1'b0;
    repeat (200) @(negedge clk);
    rx_en = 1'b0;
    @(negedge clk);
    chk("R10 flushed", int'(rd_avail), 0);
    chk("R10 overrun cleared", int'(overrun), 0);
    rx_in = 1'b1;
    repeat (10) @(negedge clk);
    rx_en = 1'b1;
    idle(1000);
    chk("R10 partial frame discarded", int'(rd_avail), 0);
    send_frame(8'hE7, 1'b0, 1'b1, 1'b0); idle(100);
    chk("R10 recovers after enable", int'(rd_data), 'hE7);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule